// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block runs the host end of one programmed-I/O data transfer on a parallel ATA bus. A local agent raises a single-cycle request while the block signals that it is idle. The request carries a direction, a chip-select pattern, a 3-bit register address and, for writes, a 16-bit word. The block then steps through the bus phases in order. It drives the selects and address first, asserts the matching strobe, and decides whether to stretch the strobe from the device ready line. It then releases the strobe, holds the address for a programmed time and lets the bus recover. At the end it reports completion with a single-cycle pulse, which carries the read word and an error flag.

Every phase length is a clock-cycle count taken from a configuration input. A count of zero acts as one. The ready line is asynchronous and passes through a synchronizer before use. It is examined once, a programmed number of cycles into the strobe, and ready low at that point starts wait states. Ready may dip low and come back high before that point without any effect. A waited transfer ends when ready returns; read data is latched at that moment. The strobe then stays low for a release interval and for at least the programmed active width. A timeout bounds the wait. When it expires, the block drops the strobe and flags an error. The bidirectional data bus appears as separate input, output and output-enable signals.

Top module: `ata_pio_host_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives: both select lines are high (inactive), both strobes are high, the data output enable is low, the done pulse is low and the request-ready output is high.
- R2: A request is taken only on a cycle where request-ready is high. Request-ready is low from the cycle after acceptance until the done pulse. A request raised while busy has no effect on the transfer in progress and starts no further transfer.
- R3: The select lines carry the inverse of the requested select pattern and the address carries the requested address. Both are driven for exactly the setup count of cycles before the strobe falls and for exactly the hold count of cycles after it rises. They stay constant while the strobe is low, and the selects return to all-ones afterwards.
- R4: A read lowers only the read strobe and a write lowers only the write strobe. The write word is driven with output enable high whenever the write strobe is low. Output enable is never high on a read.
- R5: When no wait is generated, the strobe is low for exactly the active-width count of cycles. Read data is latched from the bus at the last of those cycles.
- R6: Ready passes through a two-stage synchronizer. A wait is generated only if the synchronized ready is low in strobe cycle index min(sample count, active count) − 1, counting from 0. Ready that dips and returns high before the stage feeding that index produces no wait.
- R7: On a waited transfer, the wait phase ends on the edge two cycles after the first clock edge that samples ready high, and read data is latched on that edge. The strobe then stays low for the release count of cycles, and further if needed until it has been low for at least the active-width count.
- R8: After the hold phase the selects stay high for at least the recovery count of cycles. The done pulse does not come before the total-cycle count of cycles has elapsed since acceptance.
- R9: If synchronized ready is still low after the timeout count of wait cycles, the strobe rises on the next edge and the transfer completes through hold and recovery. The error output is then high together with the done pulse.
- R10: Each of the seven timing counts and the timeout count treats a value of zero as one.
- R11: The done pulse lasts exactly one cycle. On a read without timeout, the read-data output equals the latched bus word during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Single-cycle transfer request |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Select pattern, active high (driven inverted on the bus) |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write word |
| cfg_setup | input | 6 | Address setup cycles before strobe |
| cfg_active | input | 6 | Minimum strobe low cycles |
| cfg_hold | input | 6 | Address hold cycles after strobe |
| cfg_recover | input | 6 | Recovery cycles after hold |
| cfg_cycle | input | 6 | Minimum total transfer cycles |
| cfg_sample | input | 6 | Strobe cycles before ready is examined |
| cfg_release | input | 6 | Strobe cycles after ready returns |
| cfg_timeout | input | 12 | Wait cycles before abort |
| rsp_done | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 16 | Latched read word |
| rsp_err | output | 1 | Wait timed out (valid with done) |
| dev_cs_n | output | 2 | Active-low chip selects |
| dev_addr | output | 3 | Device register address |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_data_out | output | 16 | Bus drive value |
| dev_data_oe | output | 1 | Bus drive enable |
| dev_data_in | input | 16 | Bus sampled value |
| dev_iordy | input | 1 | Device ready, asynchronous |

## Verification
The checker takes for granted that the configuration inputs stay constant from acceptance to done, and that reset is applied before the first request. The stimulus changes configuration only in idle cycles and holds reset for several cycles at start. The bench drives ready and the data bus on the falling clock edge. So every ready change is seen first by one known rising edge, and the synchronizer latency can be counted exactly. Ready is lowered before the request when a wait is intended, and raised after a chosen number of cycles. In the glitch vector and the boundary vectors, that chosen cycle falls just before or exactly on the sample point.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_WAIT,
      PH_RELEASE,
      PH_HOLD,
      PH_RECOVER
   } phase_e;

   localparam int unsigned NUM_T     = 7;
   localparam int unsigned T_SETUP   = 0;
   localparam int unsigned T_ACTIVE  = 1;
   localparam int unsigned T_HOLD    = 2;
   localparam int unsigned T_RECOV   = 3;
   localparam int unsigned T_CYCLE   = 4;
   localparam int unsigned T_SAMPLE  = 5;
   localparam int unsigned T_RELEASE = 6;

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ata_pio_tclamp.sv
module ata_pio_tclamp #(
   parameter int unsigned W = 6
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] eff,
   output logic [W-1:0] last
);

   assign eff  = (raw == '0) ? W'(1) : raw;
   assign last = eff - W'(1);

endmodule

// File: rtl/ata_pio_dpath.sv
module ata_pio_dpath #(
   parameter int unsigned DW  = 16,
   parameter int unsigned AW  = 3,
   parameter int unsigned CSW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           req_write,
   input  logic [CSW-1:0] req_sel,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   input  logic           sel_en,
   input  logic           capture,
   input  logic [DW-1:0]  dev_data_in,
   output logic           is_write,
   output logic [CSW-1:0] dev_cs_n,
   output logic [AW-1:0]  dev_addr,
   output logic [DW-1:0]  dev_data_out,
   output logic           dev_data_oe,
   output logic [DW-1:0]  rdata
);

   logic           wr_q;
   logic [CSW-1:0] sel_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  wdata_q;
   logic [DW-1:0]  rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         sel_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (load) begin
         wr_q    <= req_write;
         sel_q   <= req_sel;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= dev_data_in;
   end

   assign is_write     = wr_q;
   assign dev_cs_n     = sel_en ? ~sel_q : '1;
   assign dev_addr     = sel_en ? addr_q : '0;
   assign dev_data_out = wdata_q;
   assign dev_data_oe  = sel_en & wr_q;
   assign rdata        = rdata_q;

endmodule

// File: rtl/ata_pio_host_seq.sv
module ata_pio_host_seq
   import ata_pio_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned AW          = 3,
   parameter int unsigned CSW         = 2,
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned TO_W        = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [CSW-1:0]   req_sel,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [CNT_W-1:0] cfg_setup,
   input  logic [CNT_W-1:0] cfg_active,
   input  logic [CNT_W-1:0] cfg_hold,
   input  logic [CNT_W-1:0] cfg_recover,
   input  logic [CNT_W-1:0] cfg_cycle,
   input  logic [CNT_W-1:0] cfg_sample,
   input  logic [CNT_W-1:0] cfg_release,
   input  logic [TO_W-1:0]  cfg_timeout,
   output logic             rsp_done,
   output logic [DW-1:0]    rsp_rdata,
   output logic             rsp_err,
   output logic [CSW-1:0]   dev_cs_n,
   output logic [AW-1:0]    dev_addr,
   output logic             dev_rd_n,
   output logic             dev_wr_n,
   output logic [DW-1:0]    dev_data_out,
   output logic             dev_data_oe,
   input  logic [DW-1:0]    dev_data_in,
   input  logic             dev_iordy
);

   localparam int unsigned TOT_W = CNT_W + 1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (TO_W < 1) begin : g_bad_to
         $error("TO_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (DW < 1 || AW < 1 || CSW < 1) begin : g_bad_bus
         $error("bus widths must be non-zero");
      end
   endgenerate

   // timing counts, clamped to a minimum of one
   logic [CNT_W-1:0] t_raw  [NUM_T];
   logic [CNT_W-1:0] t_eff  [NUM_T];
   logic [CNT_W-1:0] t_last [NUM_T];
   logic [TO_W-1:0]  to_eff;
   logic [TO_W-1:0]  to_last;

   assign t_raw[T_SETUP]   = cfg_setup;
   assign t_raw[T_ACTIVE]  = cfg_active;
   assign t_raw[T_HOLD]    = cfg_hold;
   assign t_raw[T_RECOV]   = cfg_recover;
   assign t_raw[T_CYCLE]   = cfg_cycle;
   assign t_raw[T_SAMPLE]  = cfg_sample;
   assign t_raw[T_RELEASE] = cfg_release;

   generate
      for (genvar g = 0; g < NUM_T; g++) begin : g_clamp
         ata_pio_tclamp #(.W(CNT_W)) i_clamp (
            .raw  (t_raw[g]),
            .eff  (t_eff[g]),
            .last (t_last[g])
         );
      end
   endgenerate

   ata_pio_tclamp #(.W(TO_W)) i_to_clamp (
      .raw  (cfg_timeout),
      .eff  (to_eff),
      .last (to_last)
   );

   // ready synchronizer
   logic rdy_s;

   ata_pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dev_iordy),
      .q     (rdy_s)
   );

   // state and counters
   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] act_q;
   logic [TOT_W-1:0] tot_q;
   logic [TO_W-1:0]  wcnt_q;
   logic             err_q;
   logic             done_q;

   logic             load;
   logic             cnt_clr;
   logic             capture;
   logic             err_set;
   logic             done_d;
   logic             strobe_on;
   logic             sel_en;
   logic             is_write;
   logic [CNT_W-1:0] samp_last;
   logic [TOT_W-1:0] cycle_last;

   assign samp_last  = (t_eff[T_SAMPLE] < t_eff[T_ACTIVE]) ? t_last[T_SAMPLE]
                                                           : t_last[T_ACTIVE];
   assign cycle_last = TOT_W'(t_last[T_CYCLE]);

   always_comb begin
      phase_d = phase_q;
      load    = 1'b0;
      cnt_clr = 1'b0;
      capture = 1'b0;
      err_set = 1'b0;
      done_d  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               load    = 1'b1;
               cnt_clr = 1'b1;
               phase_d = PH_SETUP;
            end
         end
         PH_SETUP: begin
            if (cnt_q == t_last[T_SETUP]) begin
               cnt_clr = 1'b1;
               phase_d = PH_ACTIVE;
            end
         end
         PH_ACTIVE: begin
            if (cnt_q == samp_last && !rdy_s) begin
               cnt_clr = 1'b1;
               phase_d = PH_WAIT;
            end else if (cnt_q == t_last[T_ACTIVE]) begin
               cnt_clr = 1'b1;
               capture = 1'b1;
               phase_d = PH_HOLD;
            end
         end
         PH_WAIT: begin
            if (rdy_s) begin
               cnt_clr = 1'b1;
               capture = 1'b1;
               phase_d = PH_RELEASE;
            end else if (wcnt_q == to_last) begin
               cnt_clr = 1'b1;
               err_set = 1'b1;
               phase_d = PH_HOLD;
            end
         end
         PH_RELEASE: begin
            if (cnt_q >= t_last[T_RELEASE] && act_q >= t_last[T_ACTIVE]) begin
               cnt_clr = 1'b1;
               phase_d = PH_HOLD;
            end
         end
         PH_HOLD: begin
            if (cnt_q == t_last[T_HOLD]) begin
               cnt_clr = 1'b1;
               phase_d = PH_RECOVER;
            end
         end
         PH_RECOVER: begin
            if (cnt_q >= t_last[T_RECOV] && tot_q >= cycle_last) begin
               cnt_clr = 1'b1;
               done_d  = 1'b1;
               phase_d = PH_IDLE;
            end
         end
         default: begin
            cnt_clr = 1'b1;
            phase_d = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= done_d;
         if (cnt_clr || phase_q == PH_IDLE) cnt_q <= '0;
         else if (cnt_q != '1)              cnt_q <= cnt_q + 1'b1;
      end
   end

   // strobe-low cycle count for the minimum active width on waited transfers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    act_q <= '0;
      else if (load)                 act_q <= '0;
      else if (strobe_on && act_q != '1) act_q <= act_q + 1'b1;
   end

   // cycles since acceptance, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   tot_q <= '0;
      else if (load)                                tot_q <= '0;
      else if (phase_q != PH_IDLE && tot_q != '1)   tot_q <= tot_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wcnt_q <= '0;
      else if (phase_q != PH_WAIT) wcnt_q <= '0;
      else if (wcnt_q != '1)      wcnt_q <= wcnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (load)    err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
   end

   assign strobe_on = phase_q inside {PH_ACTIVE, PH_WAIT, PH_RELEASE};
   assign sel_en    = phase_q inside {PH_SETUP, PH_ACTIVE, PH_WAIT, PH_RELEASE, PH_HOLD};

   ata_pio_dpath #(.DW(DW), .AW(AW), .CSW(CSW)) i_dpath (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .req_write    (req_write),
      .req_sel      (req_sel),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .sel_en       (sel_en),
      .capture      (capture),
      .dev_data_in  (dev_data_in),
      .is_write     (is_write),
      .dev_cs_n     (dev_cs_n),
      .dev_addr     (dev_addr),
      .dev_data_out (dev_data_out),
      .dev_data_oe  (dev_data_oe),
      .rdata        (rsp_rdata)
   );

   assign dev_rd_n  = ~(strobe_on & ~is_write);
   assign dev_wr_n  = ~(strobe_on &  is_write);
   assign req_ready = (phase_q == PH_IDLE);
   assign rsp_done  = done_q;
   assign rsp_err   = done_q & err_q;

endmodule

// File: rtl/ata_pio_host_seq_chk.sv
module ata_pio_host_seq_chk #(
   parameter int unsigned AW  = 3,
   parameter int unsigned CSW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_ready,
   input logic           rsp_done,
   input logic           rsp_err,
   input logic [CSW-1:0] dev_cs_n,
   input logic [AW-1:0]  dev_addr,
   input logic           dev_rd_n,
   input logic           dev_wr_n,
   input logic           dev_data_oe
);

   logic strobe;
   assign strobe = !dev_rd_n || !dev_wr_n;

   // R4
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dev_rd_n && !dev_wr_n));

   // R4
   oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_data_oe |-> dev_rd_n);

   // R3
   sel_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (dev_cs_n != '1));

   // R3
   sel_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> ($past(dev_cs_n) != '1));

   // R3
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && $past(strobe)) |-> $stable(dev_addr));

   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !req_ready);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R9
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

endmodule

bind ata_pio_host_seq ata_pio_host_seq_chk #(.AW(AW), .CSW(CSW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rsp_done    (rsp_done),
   .rsp_err     (rsp_err),
   .dev_cs_n    (dev_cs_n),
   .dev_addr    (dev_addr),
   .dev_rd_n    (dev_rd_n),
   .dev_wr_n    (dev_wr_n),
   .dev_data_oe (dev_data_oe)
);

// File: tb/test_ata_pio_host_seq.sv
`timescale 1ns/1ps
module test_ata_pio_host_seq;

   typedef struct packed {
      logic        wr;
      logic [1:0]  sel;
      logic [2:0]  addr;
      logic [15:0] data;
      logic [5:0]  t1;
      logic [5:0]  t2;
      logic [5:0]  t9;
      logic [5:0]  t2i;
      logic [5:0]  t0;
      logic [5:0]  ta;
      logic [5:0]  tb;
      logic [11:0] to;
      int          k;    // cycle at which ready is raised; -1: never lowered
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'b01, 3'd5, 16'hA5A5, 6'd3, 6'd6, 6'd2, 6'd3, 6'd10, 6'd3, 6'd2, 12'd100, -1},
      '{1'b1, 2'b10, 3'd2, 16'h1234, 6'd2, 6'd4, 6'd1, 6'd2, 6'd20, 6'd2, 6'd1, 12'd100, -1},
      '{1'b0, 2'b01, 3'd6, 16'h5A3C, 6'd2, 6'd4, 6'd2, 6'd2, 6'd5,  6'd3, 6'd2, 12'd50,  10},
      '{1'b0, 2'b10, 3'd1, 16'h0F0F, 6'd3, 6'd6, 6'd1, 6'd1, 6'd1,  6'd4, 6'd1, 12'd50,  2},
      '{1'b1, 2'b01, 3'd3, 16'hBEEF, 6'd1, 6'd12,6'd3, 6'd1, 6'd4,  6'd2, 6'd1, 12'd50,  2},
      '{1'b0, 2'b01, 3'd4, 16'h7777, 6'd2, 6'd5, 6'd2, 6'd2, 6'd1,  6'd2, 6'd1, 12'd6,   1000},
      '{1'b0, 2'b11, 3'd0, 16'hC3C3, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0,  6'd0, 6'd0, 12'd0,   -1},
      '{1'b0, 2'b01, 3'd7, 16'h1111, 6'd2, 6'd3, 6'd1, 6'd1, 6'd1,  6'd3, 6'd1, 12'd50,  3},
      '{1'b0, 2'b01, 3'd7, 16'h2222, 6'd2, 6'd3, 6'd1, 6'd1, 6'd1,  6'd3, 6'd1, 12'd50,  2}
   };
   string vtag [NV] = '{"R5", "R5", "R7", "R6", "R7", "R9", "R10", "R6", "R6"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_sel = '0;
   logic [2:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [5:0]  cfg_setup = 6'd1, cfg_active = 6'd1, cfg_hold = 6'd1, cfg_recover = 6'd1;
   logic [5:0]  cfg_cycle = 6'd1, cfg_sample = 6'd1, cfg_release = 6'd1;
   logic [11:0] cfg_timeout = 12'd1;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic        rsp_err;
   logic [1:0]  dev_cs_n;
   logic [2:0]  dev_addr;
   logic        dev_rd_n, dev_wr_n;
   logic [15:0] dev_data_out;
   logic        dev_data_oe;
   logic [15:0] dev_data_in = 16'hDEAD;
   logic        dev_iordy = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ata_pio_host_seq i_ata_pio_host_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_hold(cfg_hold),
      .cfg_recover(cfg_recover), .cfg_cycle(cfg_cycle), .cfg_sample(cfg_sample),
      .cfg_release(cfg_release), .cfg_timeout(cfg_timeout),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .dev_cs_n(dev_cs_n), .dev_addr(dev_addr), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
      .dev_data_out(dev_data_out), .dev_data_oe(dev_data_oe),
      .dev_data_in(dev_data_in), .dev_iordy(dev_iordy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int cl(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // expected strobe span, done cycle and error from the requirements
   function automatic void expect_of(input vec_t v, output int span, output int done_at,
                                     output bit err);
      int t1, t2, t9, t2i, t0, ta, tb, to, s, send;
      t1 = cl(v.t1); t2 = cl(v.t2); t9 = cl(v.t9); t2i = cl(v.t2i);
      t0 = cl(v.t0); ta = cl(v.ta); tb = cl(v.tb); to = cl(int'(v.to));
      s  = ((ta < t2) ? ta : t2) - 1;
      err = 1'b0;
      if (v.k < 0 || v.k + 1 < t1 + s) begin
         send = t1 + t2;
      end else if (t1 + s + to < v.k + 2) begin
         err  = 1'b1;
         send = t1 + s + 1 + to;
      end else begin
         send = t1 + mx(v.k + 3 - t1 + tb, t2);
      end
      span    = send - t1;
      done_at = mx(send + t9 + t2i, t0);
   endfunction

   task automatic run_vec(input vec_t v, input string tag, input bit poke);
      int  exp_span, exp_done, span, pre, post, bad_addr, bad_bus, got_done;
      bit  exp_err, seen, got_err, strobe, stray;
      logic [15:0] got_rd;
      expect_of(v, exp_span, exp_done, exp_err);
      span = 0; pre = 0; post = 0; bad_addr = 0; bad_bus = 0; got_done = -1;
      seen = 1'b0; got_err = 1'b0; got_rd = '0;
      @(negedge clk);
      cfg_setup = v.t1; cfg_active = v.t2; cfg_hold = v.t9; cfg_recover = v.t2i;
      cfg_cycle = v.t0; cfg_sample = v.ta; cfg_release = v.tb; cfg_timeout = v.to;
      dev_iordy   = (v.k >= 0) ? 1'b0 : 1'b1;
      dev_data_in = (v.k >= 0) ? 16'hDEAD : v.data;
      req_write = v.wr; req_sel = v.sel; req_addr = v.addr; req_wdata = v.data;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 3000; n++) begin
         if (n > 0) @(negedge clk);
         if (n == v.k) begin
            dev_iordy   = 1'b1;
            dev_data_in = v.data;
         end
         if (poke && n == 1) begin
            req_valid = 1'b1;
            req_addr  = ~v.addr;
         end
         if (poke && n == 2) req_valid = 1'b0;
         strobe = !dev_rd_n || !dev_wr_n;
         if (strobe) begin
            span++;
            seen = 1'b1;
            if (dev_addr != v.addr || dev_cs_n != ~v.sel) bad_addr++;
            if (v.wr ? (!dev_data_oe || dev_data_out != v.data || !dev_rd_n)
                     : (dev_data_oe || !dev_wr_n)) bad_bus++;
         end else if (dev_cs_n != 2'b11) begin
            if (seen) post++;
            else      pre++;
         end
         if (rsp_done) begin
            got_done = n;
            got_rd   = rsp_rdata;
            got_err  = rsp_err;
            break;
         end
      end
      chk(span == exp_span, {tag, " strobe span"}, span, exp_span);
      chk(got_done == exp_done, "R8 done cycle", got_done, exp_done);
      chk(pre == cl(v.t1), "R3 setup cycles", pre, cl(v.t1));
      chk(post == cl(v.t9), "R3 hold cycles", post, cl(v.t9));
      chk(bad_addr == 0, "R3 address during strobe", bad_addr, 0);
      chk(bad_bus == 0, "R4 strobe direction and bus drive", bad_bus, 0);
      chk(got_err == exp_err, "R9 error flag", int'(got_err), int'(exp_err));
      if (!v.wr && !exp_err)
         chk(got_rd == v.data, "R11 read data with done", int'(got_rd), int'(v.data));
      @(negedge clk);
      chk(!rsp_done, "R11 done lasts one cycle", int'(rsp_done), 0);
      dev_iordy = 1'b1;
      if (poke) begin
         stray = 1'b0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!dev_rd_n || !dev_wr_n || dev_cs_n != 2'b11) stray = 1'b1;
         end
         chk(!stray, "R2 busy request ignored", int'(stray), 0);
         req_addr = v.addr;
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, inside reset
      chk(dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && !dev_data_oe && !rsp_done,
          "R1 bus idle in reset", {dev_cs_n, dev_rd_n, dev_wr_n, dev_data_oe, rsp_done}, 6'b111100);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(req_ready && dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && !dev_data_oe,
          "R1 idle after reset", {req_ready, dev_cs_n, dev_rd_n, dev_wr_n, dev_data_oe}, 6'b111110);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], vtag[i], 1'b0);

      // R2 directed: request while busy must not disturb the transfer
      run_vec(VECS[0], "R2", 1'b1);
      // R10 directed: zero counts on a write
      run_vec('{1'b1, 2'b10, 3'd6, 16'h6A6A, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0,
                12'd0, -1}, "R10", 1'b0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule